// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block predicts the next fetch address. It compares the current fetch PC against a small, fully associative table. Each entry stores a complete branch address as its tag, the branch's last resolved target, and a saturating direction counter. The lookup is purely combinational, so it can run in the same cycle as the instruction cache access.

On a hit, the counter's most significant bit chooses the next PC:
- MSB set: the stored target.
- MSB clear: the sequential address.

On a miss, the block can use a displacement that the decoder supplies. If that displacement is negative, the branch is treated as a backward loop branch, predicted taken, and the next PC is the PC plus the displacement. In every other miss case the block predicts sequential fetch.

The execution stage reports resolved branches through an update port:
- A resolved branch that is already in the table has its target rewritten and its counter trained.
- A taken branch that is not in the table gets a new entry. The new entry goes into the oldest slot in round-robin order.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: any lookup returns hit_o=0, and with disp_valid_i=0 it returns next_pc_o = fetch_pc_i + 4 and pred_taken_o=0.
- R2: On a miss with disp_valid_i=0, or with disp_valid_i=1 and a displacement whose top bit is 0, the block returns next_pc_o = fetch_pc_i + 4 and pred_taken_o=0.
- R3: On a miss with disp_valid_i=1 and a displacement whose top bit is 1 (negative), the block returns pred_taken_o=1 and next_pc_o = fetch_pc_i + disp_i (modulo 2^ADDR_W).
- R4: A taken update (upd_valid_i=1, upd_taken_i=1) for a PC that is not in the table installs an entry holding that PC and upd_target_i. The counter starts at weakly taken (binary 10). From the next cycle, a lookup of that PC returns hit_o=1, pred_taken_o=1 and next_pc_o equal to the stored target.
- R5: A not-taken update for a PC that is not in the table installs nothing: later lookups of that PC still miss.
- R6: On a hit whose counter MSB is 0, the block returns hit_o=1, pred_taken_o=0 and next_pc_o = fetch_pc_i + 4.
- R7: An update to a present PC trains its 2-bit counter:
  - taken increments it, saturating at 11;
  - not taken decrements it, saturating at 00;
  - prediction is taken exactly when the counter is 10 or 11.
- R8: An update to a present PC writes upd_target_i into that same entry. It never creates a second entry and does not advance the replacement order.
- R9: The table has 8 entries. Allocations fill slots in round-robin order, so when the table is full a new allocation replaces the entry allocated earliest, and all other entries are kept.
- R10: On a hit the dynamic counter decides the prediction, even when a negative displacement is also supplied.
- R11: Updates take effect at the next rising clock edge. A lookup in the same cycle as an update sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | ADDR_W | Fetch address to look up |
| disp_valid_i | input | 1 | A decoded displacement is present |
| disp_i | input | ADDR_W | Decoded branch displacement, two's complement |
| hit_o | output | 1 | Fetch PC matches a valid entry |
| pred_taken_o | output | 1 | Branch predicted taken |
| next_pc_o | output | ADDR_W | Predicted next fetch address |
| upd_valid_i | input | 1 | Resolved branch report is valid |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_target_i | input | ADDR_W | Resolved target address |
| upd_taken_i | input | 1 | Resolved direction |

## Verification
Internal faults in this block show up at the ports as follows:
- A wrong tag, a lost valid bit or a misplaced replacement pointer shows at the next lookup of the affected PC, as a hit that should be a miss or the reverse. A pointer fault may only appear after the table has wrapped, on the ninth allocation.
- A counter that trains or saturates wrongly is invisible while the counter stays on the same side of the threshold. It surfaces only after a further update crosses the MSB, so the counter tests walk both saturation limits.
- A wrong stored target or a faulty static rule changes next_pc_o in the same cycle as the lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CNT_W = 2;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_INIT = cnt_t'(1) << (CNT_W - 1);  // weakly taken
  localparam cnt_t CNT_MAX  = '1;
  localparam cnt_t CNT_MIN  = '0;

  function automatic cnt_t cnt_train(input cnt_t c, input logic taken);
    if (taken) return (c == CNT_MAX) ? c : c + cnt_t'(1);
    else       return (c == CNT_MIN) ? c : c - cnt_t'(1);
  endfunction
endpackage

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ADDR_W-1:0] tags_i [ENTRIES],
  input  logic [ADDR_W-1:0] key_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) idx_o = IDX_W'(i);
  end
  assign hit_o = |match;

  // duplicates would make the encoder ambiguous
  AST_MATCH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R8
endmodule

// File: rtl/btb_repl_ptr.sv
module btb_repl_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == IDX_W'(ENTRIES - 1)) ? '0 : ptr_o + IDX_W'(1);
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              disp_valid_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic              hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_taken_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  cnt_t               cnt_q [ENTRIES];

  logic             lk_hit, upd_hit, alloc;
  logic [IDX_W-1:0] lk_idx, upd_idx, ptr;

  btb_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_lk_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .tags_i(tag_q),
    .key_i(fetch_pc_i), .hit_o(lk_hit), .idx_o(lk_idx));

  btb_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_upd_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .tags_i(tag_q),
    .key_i(upd_pc_i), .hit_o(upd_hit), .idx_o(upd_idx));

  assign alloc = upd_valid_i && upd_taken_i && !upd_hit;

  btb_repl_ptr #(.ENTRIES(ENTRIES)) i_repl (
    .clk_i, .rst_ni, .adv_i(alloc), .ptr_o(ptr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        cnt_q[i] <= CNT_MIN;
      end
    end else if (upd_valid_i) begin
      if (upd_hit) begin
        tgt_q[upd_idx] <= upd_target_i;
        cnt_q[upd_idx] <= cnt_train(cnt_q[upd_idx], upd_taken_i);
      end else if (upd_taken_i) begin
        valid_q[ptr] <= 1'b1;
        tag_q[ptr]   <= upd_pc_i;
        tgt_q[ptr]   <= upd_target_i;
        cnt_q[ptr]   <= CNT_INIT;
      end
    end
  end

  // lookup path
  logic [ADDR_W-1:0] seq_pc;
  logic              dyn_taken, static_taken;
  assign seq_pc       = fetch_pc_i + ADDR_W'(INST_BYTES);
  assign dyn_taken    = cnt_q[lk_idx][CNT_W-1];
  assign static_taken = disp_valid_i && disp_i[ADDR_W-1];

  always_comb begin
    hit_o = lk_hit;
    if (lk_hit) begin
      pred_taken_o = dyn_taken;
      next_pc_o    = dyn_taken ? tgt_q[lk_idx] : seq_pc;
    end else if (static_taken) begin
      pred_taken_o = 1'b1;
      next_pc_o    = fetch_pc_i + disp_i;
    end else begin
      pred_taken_o = 1'b0;
      next_pc_o    = seq_pc;
    end
  end

  AST_ALLOC_INSTALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> valid_q[$past(ptr)] && tag_q[$past(ptr)] == $past(upd_pc_i)); // R4
  AST_NT_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && !upd_hit) |=> $stable(valid_q)); // R5
  AST_HIT_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit) |=> $stable(ptr)); // R8
  AST_CNT_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && upd_taken_i && cnt_q[upd_idx] == CNT_MAX)
      |=> cnt_q[$past(upd_idx)] == CNT_MAX); // R7
  AST_CNT_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && !upd_taken_i && cnt_q[upd_idx] == CNT_MIN)
      |=> cnt_q[$past(upd_idx)] == CNT_MIN); // R7
endmodule

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0, disp = '0, upd_pc = '0, upd_tgt = '0;
  logic          disp_v = 1'b0, upd_v = 1'b0, upd_tk = 1'b0;
  logic          hit, ptk;
  logic [AW-1:0] npc;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  btb_predictor i_btb_predictor (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc), .disp_valid_i(disp_v),
    .disp_i(disp), .hit_o(hit), .pred_taken_o(ptk), .next_pc_o(npc),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_target_i(upd_tgt),
    .upd_taken_i(upd_tk));

  task automatic look(input logic [AW-1:0] pc, input logic dv, input logic [AW-1:0] d);
    fetch_pc = pc; disp_v = dv; disp = d;
    #1;
  endtask

  task automatic chk(input string req, input logic eh, input logic et, input logic [AW-1:0] en);
    n_chk++;
    if (hit !== eh || ptk !== et || npc !== en) begin
      n_fail++;
      $display("FAIL %s: got hit=%0b taken=%0b npc=%h, exp hit=%0b taken=%0b npc=%h",
               req, hit, ptk, npc, eh, et, en);
    end
  endtask

  task automatic update(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic tk);
    @(negedge clk);
    upd_v = 1'b1; upd_pc = pc; upd_tgt = tgt; upd_tk = tk;
    @(posedge clk);
    #1 upd_v = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    look(32'h0000_1000, 1'b0, '0);    chk("R1", 0, 0, 32'h0000_1004);
    look(32'hFFFF_FFFC, 1'b0, '0);    chk("R1", 0, 0, 32'h0000_0000);
  endtask

  task automatic t_static();
    @(negedge clk);
    look(32'h0000_4000, 1'b0, 32'hFFFF_FFC0); chk("R2", 0, 0, 32'h0000_4004);
    look(32'h0000_4000, 1'b1, 32'h0000_0080); chk("R2", 0, 0, 32'h0000_4004);
    look(32'h0000_4000, 1'b1, 32'hFFFF_FFC0); chk("R3", 0, 1, 32'h0000_3FC0);
    look(32'h0000_0010, 1'b1, 32'h8000_0000); chk("R3", 0, 1, 32'h8000_0010);
  endtask

  task automatic t_alloc();
    @(negedge clk);
    upd_v = 1'b1; upd_pc = 32'h0000_1000; upd_tgt = 32'h0000_2000; upd_tk = 1'b1;
    look(32'h0000_1000, 1'b0, '0);    chk("R11", 0, 0, 32'h0000_1004);
    @(posedge clk); #1 upd_v = 1'b0;
    look(32'h0000_1000, 1'b0, '0);    chk("R4", 1, 1, 32'h0000_2000);
    update(32'h0000_3000, 32'h0000_3100, 1'b0);
    look(32'h0000_3000, 1'b0, '0);    chk("R5", 0, 0, 32'h0000_3004);
  endtask

  task automatic t_counter();
    logic [AW-1:0] a = 32'h0000_1000;
    update(a, 32'h0000_2000, 1'b0);   // 2 -> 1
    look(a, 1'b0, '0);                chk("R6", 1, 0, 32'h0000_1004);
    look(a, 1'b1, 32'hFFFF_FF00);     chk("R10", 1, 0, 32'h0000_1004);
    update(a, 32'h0000_2000, 1'b1);   // 1 -> 2
    look(a, 1'b0, '0);                chk("R7", 1, 1, 32'h0000_2000);
    update(a, 32'h0000_2000, 1'b1);   // 3
    update(a, 32'h0000_2000, 1'b1);   // stays 3
    update(a, 32'h0000_2000, 1'b0);   // 2
    look(a, 1'b0, '0);                chk("R7", 1, 1, 32'h0000_2000);
    update(a, 32'h0000_2000, 1'b0);   // 1
    look(a, 1'b0, '0);                chk("R7", 1, 0, 32'h0000_1004);
    update(a, 32'h0000_2000, 1'b0);   // 0
    update(a, 32'h0000_2000, 1'b0);   // stays 0
    update(a, 32'h0000_2000, 1'b1);   // 1
    look(a, 1'b0, '0);                chk("R7", 1, 0, 32'h0000_1004);
    update(a, 32'h0000_2400, 1'b1);   // 2, new target
    look(a, 1'b0, '0);                chk("R8", 1, 1, 32'h0000_2400);
  endtask

  task automatic t_replace();
    do_reset();
    for (int k = 0; k < 8; k++)
      update(32'h0000_8000 + 32'(16 * k), 32'h0000_9000 + 32'(16 * k), 1'b1);
    update(32'h0000_8000, 32'h0000_A000, 1'b1);  // present: no allocation
    look(32'h0000_8000, 1'b0, '0);    chk("R8", 1, 1, 32'h0000_A000);
    update(32'h0000_8080, 32'h0000_9080, 1'b1);  // ninth distinct
    look(32'h0000_8000, 1'b0, '0);    chk("R9", 0, 0, 32'h0000_8004);
    for (int k = 1; k < 9; k++) begin
      look(32'h0000_8000 + 32'(16 * k), 1'b0, '0);
      chk("R9", 1, 1, 32'h0000_9000 + 32'(16 * k));
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_static();
    t_alloc();
    t_counter();
    t_replace();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule